// File: doc/BRIEF.md
# MDIO Management Master

This block is the management master for the two-wire PHY management bus. It gives a host access to up to 32 external PHYs with 32 sixteen-bit registers each. The host programs the block through two registers on a simple write/read port. One is a control word that selects the PHY, the register and the direction, and that starts the transfer. The other is a 16-bit data word. When a transfer is started, the block sends one complete management frame on the serial line and holds a busy flag until the frame has finished.

The management clock is produced inside the block by dividing the system clock by `CLK_DIV`. The default of 60 gives about 1.67 MHz from 100 MHz. The data line is split into an output, an output enable and an input, so that a pad tristate can be placed outside the block. Outgoing bits change together with the falling management clock. Returned bits are sampled at the rising management clock. On a read, the 16 bits that the PHY returns are loaded into the data register.

Top module: `mdio_master`

## Requirements
- R1: Reset (synchronous, active high) sets busy low, output enable low, data output high and management clock low.
- R2: The management clock has a period of `CLK_DIV` system cycles, with `CLK_DIV/2` cycles high.
- R3: A host write to the control register (`reg_sel`=0) with bit 15 set starts a frame, and `busy` is high in the cycle after that write.
- R4: Each frame sends, MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), PHY address from control bits [9:5], then register address from control bits [4:0].
- R5: On a write (control bit 10 = 0), the block drives turnaround `10` and then the 16 bits of the data register, and output enable stays high for all 64 bit times.
- R6: On a read (control bit 10 = 1), output enable is low for the two turnaround and sixteen data bit times. The bits sampled at the rising management clock are stored MSB first in the data register.
- R7: The data output changes only on system edges where the management clock falls.
- R8: After the last data bit time, busy goes low, output enable is low and the data output rests at 1, with no further frame.
- R9: While busy is high, host writes to either register are ignored.
- R10: Reads return their value one cycle after `reg_sel` is set. Control reads give {busy, written bits [14:0]}, and data reads give the data register.
- R11: A control write with bit 15 clear updates the stored fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data for `reg_sel` |
| busy | output | 1 | Frame pending or in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The assertions assume that `CLK_DIV` is even and at least 4, and that the host changes its registers only through the write port, so that the stored command stays fixed while a frame is in flight. They do not depend on `mdio_i` at all. The bench drives `mdio_i` only after a rising management clock, acting as a PHY would. It also issues writes during busy only to test that they are ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS = 32;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int FRAME_W  = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int REL_IDX  = DATA_W + 2;  // bits below this index are released on a read

  localparam int CTL_START = 15;
  localparam int CTL_RD    = 10;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign rise_evt = (cnt == CW'(HALF - 1));
  assign fall_evt = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + CW'(1);
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end

  a_r2_rise_sets_mdc: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> mdc);
  a_r2_fall_clears_mdc: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !mdc);
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_evt, fall_evt}));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              launch,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic               active;
  logic               rd_q;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   nxt_idx;
  logic               nxt_oe;

  always_comb begin
    nxt_idx = idx - IDX_W'(1);
    nxt_oe  = !rd_q || (nxt_idx >= IDX_W'(REL_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      active  <= 1'b0;
      rd_q    <= 1'b0;
      idx     <= '0;
      frame   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch && !busy) begin
        busy   <= 1'b1;
        active <= 1'b0;
        rd_q   <= cmd.rd;
        frame  <= {{PRE_BITS{1'b1}}, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
                   cmd.phy, cmd.regad, 2'b10, wdata};
      end else if (busy && fall_evt) begin
        if (!active) begin
          active  <= 1'b1;
          idx     <= IDX_W'(FRAME_W - 1);
          mdio_o  <= frame[FRAME_W-1];
          mdio_oe <= 1'b1;
        end else if (idx == '0) begin
          busy    <= 1'b0;
          active  <= 1'b0;
          done    <= 1'b1;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= nxt_idx;
          mdio_oe <= nxt_oe;
          mdio_o  <= nxt_oe ? frame[nxt_idx] : 1'b1;
        end
      end
      if (busy && active && rd_q && rise_evt && (idx < IDX_W'(DATA_W)))
        rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
  end

  a_r3_launch_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (launch && !busy) |=> busy);
  a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && mdio_o));
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r6_read_tail_released: assert property (@(posedge clk) disable iff (rst)
    (active && rd_q && (idx < IDX_W'(REL_IDX))) |-> !mdio_oe);
  a_r5_write_driven: assert property (@(posedge clk) disable iff (rst)
    (active && !rd_q) |-> mdio_oe);
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $past(fall_evt));
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              seq_busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_capture,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              launch,
  output logic              host_busy,
  output cmd_t              cmd,
  output logic [DATA_W-1:0] wdata
);
  logic [CTL_START-1:0] ctl;

  assign host_busy = seq_busy || launch;
  assign cmd.rd    = ctl[CTL_RD];
  assign cmd.phy   = ctl[2*ADDR_W-1:ADDR_W];
  assign cmd.regad = ctl[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      wdata     <= '0;
      launch    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      launch <= 1'b0;
      if (reg_wr && !host_busy) begin
        if (!reg_sel) begin
          ctl    <= reg_wdata[CTL_START-1:0];
          launch <= reg_wdata[CTL_START];
        end else begin
          wdata  <= reg_wdata;
        end
      end
      if (done && cmd.rd) wdata <= rd_capture;
      reg_rdata <= reg_sel ? wdata : {host_busy, ctl};
    end
  end

  a_r9_ctl_held_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && host_busy) |=> $stable(ctl));
  a_r9_data_held_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && host_busy) |=> $stable(wdata));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 60
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              rise_evt, fall_evt;
  logic              launch, seq_busy, done;
  cmd_t              cmd;
  logic [DATA_W-1:0] wdata, rd_capture;

  mdio_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_host_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .seq_busy(seq_busy), .done(done),
    .rd_capture(rd_capture), .reg_rdata(reg_rdata), .launch(launch),
    .host_busy(busy), .cmd(cmd), .wdata(wdata)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .launch(launch), .cmd(cmd), .wdata(wdata), .mdio_i(mdio_i),
    .busy(seq_busy), .done(done), .rdata(rd_capture),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mdio_oe && mdio_o && !mdc));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int DIV = 8;
  localparam int NV  = 6;
  // {rd, phy, reg, data (write payload or PHY reply)}
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b0, 5'd0,  5'd0,  16'h0000},
    {1'b0, 5'd31, 5'd31, 16'hFFFF},
    {1'b1, 5'd5,  5'd2,  16'hA5C3},
    {1'b1, 5'd31, 5'd0,  16'h8001},
    {1'b0, 5'd10, 5'd21, 16'h1234},
    {1'b1, 5'd0,  5'd31, 16'h7FFE}
  };

  logic clk = 0, rst = 1, reg_wr = 0, reg_sel = 0, mdio_i = 1;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic busy, mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0, r7_viol = 0;
  logic prev_o = 1;

  always #2 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) u_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(negedge clk) begin
    if (!rst && (mdio_o !== prev_o) && mdc) r7_viol++;
    prev_o = mdio_o;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic host_read(input logic sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic capture(input logic rd, input logic [15:0] reply,
                         output logic [63:0] ob, output logic [63:0] oe);
    @(posedge mdio_oe);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc); #1;
      ob[63-k] = mdio_o;
      oe[63-k] = mdio_oe;
      if (rd && k >= 47 && k <= 62) mdio_i = reply[62-k];
      else mdio_i = 1'b1;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] ob, oe, exp;
    logic [15:0] rv;
    logic [15:0] smp;
    int hi;
    logic per_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mdio_oe && mdio_o && !mdc, "R1",
          {busy, mdio_oe, mdio_o, mdc}, 4'b0010);
    rst = 0;

    // R2 clock period and duty
    @(posedge mdc);
    for (int i = 0; i < 16; i++) begin @(negedge clk); smp[i] = mdc; end
    hi = 0; per_ok = 1;
    for (int i = 0; i < 8; i++) begin
      if (smp[i]) hi++;
      if (smp[i] !== smp[i+8]) per_ok = 0;
    end
    check(per_ok && hi == DIV / 2, "R2", hi, DIV / 2);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic rd; logic [4:0] phy, ra; logic [15:0] d;
      {rd, phy, ra, d} = VEC[v];
      if (!rd) host_write(1'b1, d);
      host_write(1'b0, {1'b1, 4'b0, rd, phy, ra});
      check(busy, "R3", busy, 1);
      capture(rd, d, ob, oe);
      exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
      check(ob[63:18] == exp[63:18], "R4", ob, exp);
      if (!rd) begin
        check(ob[17:0] == exp[17:0], "R5 data", ob, exp);
        check(oe == '1, "R5 oe", oe, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        check(oe == {{46{1'b1}}, 18'b0}, "R6 oe", oe, {{46{1'b1}}, 18'b0});
      end
      wait_idle();
      @(negedge clk);
      check(!mdio_oe && mdio_o, "R8", {mdio_oe, mdio_o}, 2'b01);
      host_read(1'b1, rv);
      check(rv == d, rd ? "R6 data" : "R10 data", rv, d);
      host_read(1'b0, rv);
      check(rv == {1'b0, 4'b0, rd, phy, ra}, "R10 ctl", rv, {1'b0, 4'b0, rd, phy, ra});
    end

    // R8 no further frame
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (mdio_oe || busy) break;
    end
    check(!mdio_oe && !busy, "R8 quiet", {mdio_oe, busy}, 0);

    // R9 writes during busy ignored
    host_write(1'b1, 16'h00FF);
    host_write(1'b0, {1'b1, 4'b0, 1'b0, 5'd3, 5'd4});
    fork
      capture(1'b0, 16'h0, ob, oe);
      begin
        host_write(1'b0, {1'b1, 4'b0, 1'b1, 5'd9, 5'd9});
        host_write(1'b1, 16'hDEAD);
      end
    join
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'h00FF};
    check(ob == exp, "R9 frame", ob, exp);
    wait_idle();
    host_read(1'b0, rv);
    check(rv == {6'b0, 5'd3, 5'd4}, "R9 ctl", rv, {6'b0, 5'd3, 5'd4});
    host_read(1'b1, rv);
    check(rv == 16'h00FF, "R9 data", rv, 16'h00FF);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (mdio_oe || busy) break;
    end
    check(!mdio_oe && !busy, "R9 no frame", {mdio_oe, busy}, 0);

    // R11 control write without start
    host_write(1'b0, {1'b0, 4'b0101, 1'b1, 5'd7, 5'd9});
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (mdio_oe || busy) break;
    end
    check(!mdio_oe && !busy, "R11 idle", {mdio_oe, busy}, 0);
    host_read(1'b0, rv);
    check(rv == {1'b0, 4'b0101, 1'b1, 5'd7, 5'd9}, "R11 ctl", rv,
          {1'b0, 4'b0101, 1'b1, 5'd7, 5'd9});

    // R1 reset in mid-frame
    host_write(1'b0, {1'b1, 4'b0, 1'b1, 5'd1, 5'd1});
    repeat (100) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check(!busy && !mdio_oe && mdio_o && !mdc, "R1 mid", {busy, mdio_oe, mdio_o, mdc}, 4'b0010);
    rst = 0;
    repeat (2 * DIV) @(negedge clk);
    check(!busy && !mdio_oe, "R1 after", {busy, mdio_oe}, 0);

    // R7 change alignment
    check(r7_viol == 0, "R7", r7_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule